// File: doc/BRIEF.md
# Dual-clock serial FIFO with ready flags

This block is a one-bit-wide elastic store between two clock domains. A producer writes a bit on a rising edge of the write clock when it asserts its enable and the block shows input-ready. A consumer takes a bit on a rising edge of the read clock when it asserts its enable and the block shows output-ready. The two clocks may be unrelated in frequency and phase, or identical. A dual-channel device is built by placing the block twice.

The storage array holds `DEPTH` bits. A separate output register sits after the array and presents the oldest bit before it is consumed. A bit held in that register no longer counts as stored. With no reads, the block therefore accepts `DEPTH + 1` bits before input-ready falls.

Pointers cross between the domains as Gray codes. The read pointer reaches the write side through `WSYNC` write-clock flops, and the write pointer reaches the read side through `RSYNC` read-clock flops. A half-full flag and a combined near-full/near-empty flag are registered in the write-clock domain. They are derived from the write pointer and the synchronised read pointer.

Top module: `serial_elastic_fifo`

## Requirements
- R1: With no reads, the block accepts exactly `DEPTH + 1` bits after reset: `DEPTH` in the array and one in the output register.
- R2: A bit is stored only on a rising `wr_clk` edge at which `wr_en` and `in_rdy` are both 1. Bits offered while `in_rdy` is 0 never appear at the output.
- R3: A bit is consumed only on a rising `rd_clk` edge at which `rd_en` and `out_rdy` are both 1. Bits leave in the order they were accepted. `rd_en` while `out_rdy` is 0 consumes nothing.
- R4: `in_rdy` is 0 while `rst_n` is 0 and for the first write-clock edge after release. It is 1 within four write-clock edges of release when the array is not full. It is 0 while `DEPTH` bits are stored.
- R5: `out_rdy` is 0 during reset and when nothing is held. It becomes 1 after a write once the write pointer has passed `RSYNC` (default 3) read-clock flops. The read-side pointer path has more stages than the write-side path (`WSYNC`, default 2).
- R6: `half_full` is 1 exactly when the stored count (excluding the output register) is at least `DEPTH/2`. It is 0 during reset.
- R7: `near_edge` is 1 exactly when the stored count is at most `MARGIN` (default 8), or the free count `DEPTH - stored` is at most `MARGIN`. It is 1 during reset.
- R8: While `out_rdy` is 1, `rd_bit` shows the oldest accepted bit not yet consumed. That bit is excluded from the count used by R6 and R7.
- R9: While `out_rdy` is 1 and `rd_en` is 0, `out_rdy` stays 1 and `rd_bit` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised in each domain |
| wr_en | input | 1 | Write request |
| wr_bit | input | 1 | Bit to write |
| in_rdy | output | 1 | Space available; a write occurs when this and `wr_en` are 1 |
| rd_en | input | 1 | Read request |
| rd_bit | output | 1 | Oldest unconsumed bit (lookahead register) |
| out_rdy | output | 1 | `rd_bit` is valid; a read occurs when this and `rd_en` are 1 |
| half_full | output | 1 | Stored count at least `DEPTH/2` (write domain) |
| near_edge | output | 1 | Stored count or free count at most `MARGIN` (write domain) |

## Verification
Two events can coincide. A write can land in the very cycle the output register pulls the last stored bit out of the array. A read can free a slot while the write side still sees the array full. Both are provoked by long streams with irregular enable patterns at three clock ratios: a slower reader that pins the array at full, a faster reader that keeps it at empty, and equal clock rates. A queue model fed from the accepted writes judges every consumed bit for order and value. Final counts then confirm that nothing was gained or lost at either boundary.

// File: rtl/sef_pkg.sv
`timescale 1ns/1ps
package sef_pkg;
  localparam int unsigned SEF_WSYNC_DEF  = 2;
  localparam int unsigned SEF_RSYNC_DEF  = 3;
  localparam int unsigned SEF_MARGIN_DEF = 8;

  typedef struct packed {
    logic half;
    logic near;
  } sef_lvl_t;
endpackage

// File: rtl/sef_sync.sv
`timescale 1ns/1ps
// Multi-flop synchroniser for a Gray-coded bus (STAGES >= 2).
module sef_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain_q, chain_nx;

  always_comb begin
    chain_nx[0] = d;
    for (int s = 1; s < STAGES; s++) chain_nx[s] = chain_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nx;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sef_wr_ctrl.sv
`timescale 1ns/1ps
// Write-domain control: pointer, input-ready and level flags.
module sef_wr_ctrl import sef_pkg::*; #(
  parameter  int unsigned DEPTH  = 256,
  parameter  int unsigned MARGIN = 8,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned PW     = AW + 1
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wrst_ok,
  input  logic          wr_en,
  input  logic [PW-1:0] rgray_s,
  output logic [PW-1:0] wgray,
  output logic [AW-1:0] waddr,
  output logic          we,
  output logic          ir,
  output logic          half,
  output logic          near
);
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_LVL = PW'(DEPTH / 2);
  localparam logic [PW-1:0] LOW_LVL  = PW'(MARGIN);
  localparam logic [PW-1:0] HIGH_LVL = PW'(DEPTH - MARGIN);

  logic [PW-1:0] wptr_q, wptr_nx, wgray_q, wgray_nx;
  logic [PW-1:0] rbin, lvl_now, lvl_nx;
  logic          ir_q, ir_nx;
  sef_lvl_t      flg_q, flg_nx;

  // Gray to binary for the synchronised read pointer
  always_comb begin
    rbin[PW-1] = rgray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) rbin[i] = rbin[i+1] ^ rgray_s[i];
  end

  assign we = wr_en & ir_q;

  always_comb begin
    wptr_nx     = wptr_q + {{AW{1'b0}}, we};
    wgray_nx    = wptr_nx ^ (wptr_nx >> 1);
    lvl_now     = wptr_q - rbin;
    lvl_nx      = wptr_nx - rbin;
    ir_nx       = wrst_ok & (lvl_nx != FULL_LVL);
    flg_nx.half = (lvl_nx >= HALF_LVL);
    flg_nx.near = (lvl_nx <= LOW_LVL) | (lvl_nx >= HIGH_LVL);
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      wgray_q <= '0;
      ir_q    <= 1'b0;
      flg_q   <= '{half: 1'b0, near: 1'b1};
    end else begin
      wptr_q  <= wptr_nx;
      wgray_q <= wgray_nx;
      ir_q    <= ir_nx;
      flg_q   <= flg_nx;
    end
  end

  assign wgray = wgray_q;
  assign waddr = wptr_q[AW-1:0];
  assign ir    = ir_q;
  assign half  = flg_q.half;
  assign near  = flg_q.near;

  // R2: an accepted write never lands on a full array
  p_no_overflow_r2: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_en && ir_q) |-> (lvl_now != FULL_LVL));

  // R6: the count only grows through a write, so half-full can only rise after one
  p_half_rise_r6: assert property (@(posedge wclk) disable iff (!rst_n)
    $rose(flg_q.half) |-> $past(wr_en && ir_q));

  // R7: whenever input-ready is low, the near-edge flag is high (full or reset)
  p_near_when_blocked_r7: assert property (@(posedge wclk) disable iff (!rst_n)
    !ir_q |-> flg_q.near);
endmodule

// File: rtl/sef_rd_ctrl.sv
`timescale 1ns/1ps
// Read-domain control: pointer, lookahead output register and output-ready.
module sef_rd_ctrl #(
  parameter  int unsigned DEPTH = 256,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned PW    = AW + 1
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          rrst_ok,
  input  logic          rd_en,
  input  logic [PW-1:0] wgray_s,
  input  logic          mem_bit,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic          valid,
  output logic          dout
);
  logic [PW-1:0] rptr_q, rptr_nx, rgray_q, rgray_nx;
  logic          vld_q, vld_nx, dout_q, dout_nx;
  logic          empty, fetch;

  always_comb begin
    empty    = (rgray_q == wgray_s);
    // Refill the output register when it is free or being consumed now
    fetch    = rrst_ok & ~empty & (~vld_q | rd_en);
    rptr_nx  = rptr_q + {{AW{1'b0}}, fetch};
    rgray_nx = rptr_nx ^ (rptr_nx >> 1);
    vld_nx   = fetch | (vld_q & ~rd_en);
    dout_nx  = fetch ? mem_bit : dout_q;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q  <= '0;
      rgray_q <= '0;
      vld_q   <= 1'b0;
      dout_q  <= 1'b0;
    end else begin
      rptr_q  <= rptr_nx;
      rgray_q <= rgray_nx;
      vld_q   <= vld_nx;
      dout_q  <= dout_nx;
    end
  end

  assign raddr = rptr_q[AW-1:0];
  assign rgray = rgray_q;
  assign valid = vld_q;
  assign dout  = dout_q;

  // R9: a presented bit is held until it is taken
  p_hold_r9: assert property (@(posedge rclk) disable iff (!rst_n)
    (vld_q && !rd_en) |=> (vld_q && $stable(dout_q)));

  // R3: the read pointer only ever advances by one location
  p_rptr_step_r3: assert property (@(posedge rclk) disable iff (!rst_n)
    !$stable(rptr_q) |-> (rptr_q == $past(rptr_q) + 1'b1));
endmodule

// File: rtl/serial_elastic_fifo.sv
`timescale 1ns/1ps
// Dual-clock one-bit FIFO with lookahead output and registered level flags.
module serial_elastic_fifo import sef_pkg::*; #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned MARGIN = SEF_MARGIN_DEF,
  parameter int unsigned WSYNC  = SEF_WSYNC_DEF,
  parameter int unsigned RSYNC  = SEF_RSYNC_DEF
) (
  input  logic wr_clk,
  input  logic rd_clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  output logic in_rdy,
  input  logic rd_en,
  output logic rd_bit,
  output logic out_rdy,
  output logic half_full,
  output logic near_edge
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic [1:0]    wrst_q, rrst_q;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] waddr, raddr;
  logic          we, mem_bit;
  logic          mem_q [DEPTH];

  // Reset asserted asynchronously, released through two flops per domain
  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) wrst_q <= '0;
    else        wrst_q <= {wrst_q[0], 1'b1};
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) rrst_q <= '0;
    else        rrst_q <= {rrst_q[0], 1'b1};
  end

  // Storage array: written in the write domain, read combinationally
  always_ff @(posedge wr_clk) begin
    if (we) mem_q[waddr] <= wr_bit;
  end
  assign mem_bit = mem_q[raddr];

  sef_sync #(.W(PW), .STAGES(WSYNC)) u_r2w (
    .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
  );

  sef_sync #(.W(PW), .STAGES(RSYNC)) u_w2r (
    .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
  );

  sef_wr_ctrl #(.DEPTH(DEPTH), .MARGIN(MARGIN)) u_wr (
    .wclk(wr_clk), .rst_n(rst_n), .wrst_ok(wrst_q[1]), .wr_en(wr_en),
    .rgray_s(rgray_s), .wgray(wgray), .waddr(waddr), .we(we),
    .ir(in_rdy), .half(half_full), .near(near_edge)
  );

  sef_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .rclk(rd_clk), .rst_n(rst_n), .rrst_ok(rrst_q[1]), .rd_en(rd_en),
    .wgray_s(wgray_s), .mem_bit(mem_bit), .raddr(raddr), .rgray(rgray),
    .valid(out_rdy), .dout(rd_bit)
  );
endmodule

// File: tb/serial_elastic_fifo_test.sv
`timescale 1ns/1ps
module serial_elastic_fifo_test;
  localparam int DEPTH  = 256;
  localparam int MARGIN = 8;

  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  real  rhalf  = 5.65;
  logic rst_n, wr_en, wr_bit, rd_en;
  logic in_rdy, rd_bit, out_rdy, half_full, near_edge;

  int n_chk = 0, n_fail = 0, n_acc = 0, n_rd = 0;
  bit q_ref[$];
  logic [15:0] lfsr = 16'hACE1;

  always #4 wr_clk = ~wr_clk;
  always #(rhalf) rd_clk = ~rd_clk;

  serial_elastic_fifo #(.DEPTH(DEPTH), .MARGIN(MARGIN)) uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_bit(wr_bit), .in_rdy(in_rdy),
    .rd_en(rd_en), .rd_bit(rd_bit), .out_rdy(out_rdy),
    .half_full(half_full), .near_edge(near_edge)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // Reference model: accepted writes enter the queue, reads pop and compare (R3, R8)
  always @(negedge wr_clk) begin
    if (rst_n && wr_en && in_rdy) begin
      q_ref.push_back(wr_bit);
      n_acc++;
    end
  end

  always @(negedge rd_clk) begin
    if (rst_n && rd_en && out_rdy) begin
      if (q_ref.size() == 0) chk(1'b0, "R3", "read from empty model", 1, 0);
      else begin
        bit exp_b;
        exp_b = q_ref.pop_front();
        chk(rd_bit == exp_b, "R3", "read data order", int'(rd_bit), int'(exp_b));
      end
      n_rd++;
    end
  end

  task automatic settle();
    repeat (20) @(posedge wr_clk);
    @(negedge wr_clk);
  endtask

  task automatic fill_to(input int target);
    for (int c = 0; c < 4 * DEPTH; c++) begin
      @(posedge wr_clk); #1;
      if (n_acc >= target) begin
        wr_en = 1'b0;
        break;
      end
      wr_en  = 1'b1;
      wr_bit = next_bit();
    end
    wr_en = 1'b0;
  endtask

  task automatic check_levels(input string tag);
    int lvl;
    bit exp_h, exp_n;
    lvl   = q_ref.size() - int'(out_rdy);
    exp_h = (lvl >= DEPTH / 2);
    exp_n = (lvl <= MARGIN) || (DEPTH - lvl <= MARGIN);
    chk(half_full == exp_h, "R6", {"half_full ", tag}, int'(half_full), int'(exp_h));
    chk(near_edge == exp_n, "R7", {"near_edge ", tag}, int'(near_edge), int'(exp_n));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_bit = 1'b0;
    repeat (4) @(posedge wr_clk);
    @(negedge wr_clk);
    chk(in_rdy == 1'b0, "R4", "in_rdy in reset", int'(in_rdy), 0);
    chk(out_rdy == 1'b0, "R5", "out_rdy in reset", int'(out_rdy), 0);
    chk(half_full == 1'b0, "R6", "half_full in reset", int'(half_full), 0);
    chk(near_edge == 1'b1, "R7", "near_edge in reset", int'(near_edge), 1);
    @(posedge wr_clk); #1;
    rst_n = 1'b1;
    @(posedge wr_clk);
    @(negedge wr_clk);
    chk(in_rdy == 1'b0, "R4", "in_rdy one edge after release", int'(in_rdy), 0);
    repeat (3) @(posedge wr_clk);
    @(negedge wr_clk);
    chk(in_rdy == 1'b1, "R4", "in_rdy after release", int'(in_rdy), 1);
  endtask

  task automatic t_levels();
    fill_to(9);  settle();
    chk(out_rdy == 1'b1, "R5", "out_rdy after writes", int'(out_rdy), 1);
    chk(rd_bit == q_ref[0], "R8", "lookahead bit is oldest", int'(rd_bit), int'(q_ref[0]));
    check_levels("stored 8");
    fill_to(10);  settle(); check_levels("stored 9");
    fill_to(128); settle(); check_levels("stored 127");
    fill_to(129); settle(); check_levels("stored 128");
    fill_to(248); settle(); check_levels("stored 247");
    fill_to(249); settle(); check_levels("stored 248");
    fill_to(DEPTH + 1); settle();
    chk(in_rdy == 1'b0, "R4", "in_rdy when full", int'(in_rdy), 0);
    chk(n_acc == DEPTH + 1, "R1", "bits accepted with no reads", n_acc, DEPTH + 1);
    check_levels("full");
  endtask

  task automatic t_full_ignore();
    int acc0, low_cnt;
    acc0 = n_acc; low_cnt = 0;
    for (int i = 0; i < 10; i++) begin
      @(posedge wr_clk); #1;
      wr_en = 1'b1; wr_bit = ~wr_bit;
      @(negedge wr_clk);
      if (!in_rdy) low_cnt++;
    end
    @(posedge wr_clk); #1; wr_en = 1'b0;
    chk(low_cnt == 10, "R2", "in_rdy held low while full", low_cnt, 10);
    chk(n_acc == acc0, "R2", "no write accepted while full", n_acc, acc0);
  endtask

  task automatic t_hold();
    logic b0;
    int same;
    same = 0;
    @(negedge rd_clk); b0 = rd_bit;
    for (int i = 0; i < 6; i++) begin
      @(negedge rd_clk);
      if (out_rdy && rd_bit == b0) same++;
    end
    chk(same == 6, "R9", "bit held without rd_en", same, 6);
  endtask

  task automatic t_drain();
    int rd0;
    @(posedge rd_clk); #1; rd_en = 1'b1;
    for (int c = 0; c < 8 * DEPTH; c++) begin
      @(posedge rd_clk);
      if (q_ref.size() == 0) break;
    end
    settle();
    chk(n_rd == DEPTH + 1, "R1", "bits drained", n_rd, DEPTH + 1);
    chk(out_rdy == 1'b0, "R5", "out_rdy when empty", int'(out_rdy), 0);
    chk(in_rdy == 1'b1, "R4", "in_rdy after drain", int'(in_rdy), 1);
    check_levels("empty");
    // rd_en held while empty must consume nothing (R3)
    rd0 = n_rd;
    repeat (10) @(posedge rd_clk);
    @(negedge rd_clk);
    chk(n_rd == rd0 && out_rdy == 1'b0, "R3", "reads while empty", n_rd, rd0);
    fill_to(n_acc + 3);
    settle();
    chk(n_rd == rd0 + 3, "R3", "bits after empty reads", n_rd, rd0 + 3);
    @(posedge rd_clk); #1; rd_en = 1'b0;
  endtask

  task automatic t_stream(input real half_rd, input int wr_pct, input int rd_pct,
                          input string tag);
    rhalf = half_rd;
    fork
      for (int i = 0; i < 3000; i++) begin
        @(posedge wr_clk); #1;
        wr_en  = (($urandom() % 100) < wr_pct);
        wr_bit = next_bit();
      end
      for (int i = 0; i < 3000; i++) begin
        @(posedge rd_clk); #1;
        rd_en = (($urandom() % 100) < rd_pct);
      end
    join
    @(posedge wr_clk); #1; wr_en = 1'b0;
    @(posedge rd_clk); #1; rd_en = 1'b1;
    for (int c = 0; c < 8 * DEPTH; c++) begin
      @(posedge rd_clk);
      if (q_ref.size() == 0) break;
    end
    settle();
    @(posedge rd_clk); #1; rd_en = 1'b0;
    chk(q_ref.size() == 0, "R2", {"model empty after stream ", tag}, q_ref.size(), 0);
    chk(n_rd == n_acc, "R3", {"reads equal writes ", tag}, n_rd, n_acc);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_levels();
    t_full_ignore();
    t_hold();
    t_drain();
    t_stream(5.65, 75, 55, "slow reader");
    t_stream(3.1,  50, 80, "fast reader");
    t_stream(4.0,  60, 60, "equal rates");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule